// File: doc/BRIEF.md
# Power-Up Reset Timeout Sequencer

This block keeps a device in reset after a power-on, brown-out or external reset event, and releases it only once a chain of timeouts has run. It is clocked by a free-running internal reference clock whose rate, in kilohertz, is a parameter. All delay lengths are derived from that rate. The oscillator start-up wait counts rising edges of the raw oscillator clock, which is brought into the reference domain through a two-flop synchronizer.

The chain depends on a 2-bit oscillator mode and on the kind of event that started it. It has up to three timed phases. The power-up delay runs only after a power-on or brown-out event, and only when its enable is high. The oscillator start-up count runs in the crystal modes. The PLL lock delay is a second, shorter power-up-timer run that follows the start-up count, and only in the PLL crystal mode. Any new event during any phase starts the chain again. A status field shows the current phase.

Top module: `pwrup_seq`

## Requirements
- R1: While any of `por_pulse`, `bor_pulse` or `ext_rst` is high at a clock edge, the next cycle shows `phase` = IDLE (0) and `hold_rst` = 1. This applies in every phase and abandons the phase that was running.
- R2: After the last event cycle, IDLE lasts exactly one cycle. The first applicable phase then follows, in the order power-up delay, oscillator start-up, PLL lock, DONE.
- R3: The power-up delay phase (`phase` = 1) lasts exactly REF_KHZ*PWRT_MS reference cycles. It runs only when `pwrt_en` was high and a power-on or brown-out input was high during the event window. When `pwrt_en` is low, the phase is skipped.
- R4: An event window made only of `ext_rst` cycles does not run the power-up delay.
- R5: The oscillator start-up phase (`phase` = 2) ends on the OST_EDGES-th rising edge of `osc_raw` seen during that phase. The phase changes at the third reference edge after the input rises, because of two synchronizer stages and one counting edge. Edges seen outside this phase are not counted.
- R6: Mode 00 (RC or external clock) skips both the oscillator start-up phase and the PLL lock phase. Modes 01 (LP/XT), 10 (HS) and 11 (HS with PLL) run the start-up phase.
- R7: In mode 11 only, a PLL lock phase (`phase` = 3) of exactly REF_KHZ*PLL_MS cycles follows the start-up phase.
- R8: `osc_mode` and `pwrt_en` are captured during the event window. Changes to them while the chain runs have no effect on it.
- R9: `hold_rst` is 1 in every phase except DONE (`phase` = 4). DONE, with `hold_rst` = 0, persists until the next event.
- R10: The `phase` encoding is IDLE = 0, power-up delay = 1, oscillator start-up = 2, PLL lock = 3 and DONE = 4. No other value appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| por_pulse | input | 1 | Power-on event, active high; also the synchronous reset |
| bor_pulse | input | 1 | Brown-out event, active high |
| ext_rst | input | 1 | External reset pin event, active high |
| pwrt_en | input | 1 | Enables the power-up delay phase |
| osc_mode | input | 2 | Oscillator mode: 00 RC/ext, 01 LP/XT, 10 HS, 11 HS+PLL |
| osc_raw | input | 1 | Raw oscillator clock, asynchronous |
| hold_rst | output | 1 | Device held in reset |
| phase | output | 3 | Current phase code |

## Verification
The assertions assume that a power-on event arrives before any other activity, because `por_pulse` is the only thing that initialises the state. They also assume that `osc_mode` is meaningful in every event cycle, since the checker keeps its own copy of the mode taken during events. The stimulus opens every run with a power-on pulse and always drives a defined mode. It sweeps every mode, every enable value and all three event kinds, with `osc_raw` pulses long enough for the synchronizer to see each one.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_PWRT = 3'd1,
        PH_OST  = 3'd2,
        PH_PLL  = 3'd3,
        PH_DONE = 3'd4
    } phase_e;

    typedef enum logic [1:0] {
        OM_RC    = 2'd0,
        OM_XTAL  = 2'd1,
        OM_HS    = 2'd2,
        OM_HSPLL = 2'd3
    } osc_e;

    typedef struct packed {
        osc_e mode;
        logic pwrt_go;
    } seq_cfg_t;

    function automatic logic needs_ost(osc_e m);
        return m != OM_RC;
    endfunction

    function automatic phase_e after_phase(phase_e cur, seq_cfg_t cfg);
        phase_e nxt;
        case (cur)
            PH_IDLE: begin
                if (cfg.pwrt_go)             nxt = PH_PWRT;
                else if (needs_ost(cfg.mode)) nxt = PH_OST;
                else                          nxt = PH_DONE;
            end
            PH_PWRT: nxt = needs_ost(cfg.mode) ? PH_OST : PH_DONE;
            PH_OST:  nxt = (cfg.mode == OM_HSPLL) ? PH_PLL : PH_DONE;
            default: nxt = PH_DONE;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/pwrup_edge_sync.sv
module pwrup_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[STAGES-1:0], din};
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/pwrup_timer.sv
module pwrup_timer #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          last
);
    logic [CW-1:0] cnt_q;

    assign last = tick && (cnt_q == limit - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || clr)  cnt_q <= '0;
        else if (tick)   cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/pwrup_seq.sv
module pwrup_seq
    import pwrup_pkg::*;
#(
    parameter int REF_KHZ     = 32,
    parameter int PWRT_MS     = 72,
    parameter int PLL_MS      = 2,
    parameter int OST_EDGES   = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       por_pulse,
    input  logic       bor_pulse,
    input  logic       ext_rst,
    input  logic       pwrt_en,
    input  logic [1:0] osc_mode,
    input  logic       osc_raw,
    output logic       hold_rst,
    output logic [2:0] phase
);
    localparam int PWRT_TICKS = REF_KHZ * PWRT_MS;
    localparam int PLL_TICKS  = REF_KHZ * PLL_MS;
    localparam int MAX_A      = (PWRT_TICKS > PLL_TICKS) ? PWRT_TICKS : PLL_TICKS;
    localparam int MAX_LIM    = (MAX_A > OST_EDGES) ? MAX_A : OST_EDGES;
    localparam int CW         = $clog2(MAX_LIM + 1);
    localparam logic [CW-1:0] LIM_PWRT = CW'(PWRT_TICKS);
    localparam logic [CW-1:0] LIM_PLL  = CW'(PLL_TICKS);
    localparam logic [CW-1:0] LIM_OST  = CW'(OST_EDGES);

    phase_e        phase_q;
    seq_cfg_t      cfg_q;
    logic          evt, evt_q, cold_q, cold_nx;
    logic          osc_rise, tick, last, phase_end;
    logic [CW-1:0] limit;

    assign evt     = por_pulse | bor_pulse | ext_rst;
    assign cold_nx = (evt_q & cold_q) | por_pulse | bor_pulse;

    pwrup_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (por_pulse),
        .din  (osc_raw),
        .rise (osc_rise)
    );

    always_comb begin
        tick  = 1'b0;
        limit = LIM_PWRT;
        case (phase_q)
            PH_PWRT: begin tick = 1'b1;     limit = LIM_PWRT; end
            PH_OST:  begin tick = osc_rise; limit = LIM_OST;  end
            PH_PLL:  begin tick = 1'b1;     limit = LIM_PLL;  end
            default: begin tick = 1'b0;     limit = LIM_PWRT; end
        endcase
    end

    pwrup_timer #(.CW(CW)) u_tmr (
        .clk   (clk),
        .rst   (por_pulse),
        .clr   (evt | phase_end),
        .tick  (tick),
        .limit (limit),
        .last  (last)
    );

    always_comb begin
        case (phase_q)
            PH_IDLE:                 phase_end = 1'b1;
            PH_PWRT, PH_OST, PH_PLL: phase_end = last;
            default:                 phase_end = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        evt_q <= evt;
        if (evt) begin
            phase_q       <= PH_IDLE;
            cold_q        <= cold_nx;
            cfg_q.mode    <= osc_e'(osc_mode);
            cfg_q.pwrt_go <= pwrt_en & cold_nx;
        end else if (phase_end) begin
            phase_q <= after_phase(phase_q, cfg_q);
        end
    end

    assign phase    = phase_q;
    assign hold_rst = (phase_q != PH_DONE);
endmodule

// File: rtl/pwrup_seq_chk.sv
module pwrup_seq_chk (
    input logic       clk,
    input logic       por_pulse,
    input logic       bor_pulse,
    input logic       ext_rst,
    input logic [1:0] osc_mode,
    input logic       hold_rst,
    input logic [2:0] phase
);
    logic       evt;
    logic [1:0] mode_seen;

    assign evt = por_pulse | bor_pulse | ext_rst;

    always_ff @(posedge clk) begin
        if (evt) mode_seen <= osc_mode;
    end

    p_evt_idle_r1: assert property (@(posedge clk) disable iff (por_pulse)
        evt |=> (phase == 3'd0 && hold_rst));

    p_done_sticky_r9: assert property (@(posedge clk) disable iff (por_pulse)
        (phase == 3'd4 && !evt) |=> (phase == 3'd4 && !hold_rst));

    p_pwrt_entry_r3: assert property (@(posedge clk) disable iff (por_pulse)
        (phase == 3'd1 && $past(phase) != 3'd1) |-> $past(phase) == 3'd0);

    p_ost_mode_r6: assert property (@(posedge clk) disable iff (por_pulse)
        (phase == 3'd2) |-> mode_seen != 2'd0);

    p_pll_mode_r7: assert property (@(posedge clk) disable iff (por_pulse)
        (phase == 3'd3) |-> mode_seen == 2'd3);

    p_pll_entry_r7: assert property (@(posedge clk) disable iff (por_pulse)
        (phase == 3'd3 && $past(phase) != 3'd3) |-> $past(phase) == 3'd2);

    p_phase_code_r10: assert property (@(posedge clk) disable iff (por_pulse)
        phase <= 3'd4);
endmodule

bind pwrup_seq pwrup_seq_chk u_chk (
    .clk       (clk),
    .por_pulse (por_pulse),
    .bor_pulse (bor_pulse),
    .ext_rst   (ext_rst),
    .osc_mode  (osc_mode),
    .hold_rst  (hold_rst),
    .phase     (phase)
);

// File: tb/sim_pwrup_seq.sv
module sim_pwrup_seq;
    localparam int KHZ   = 4;
    localparam int T_PW  = KHZ * 72;
    localparam int T_PLL = KHZ * 2;
    localparam int EDGES = 8;

    logic       clk = 1'b0;
    logic       por_pulse = 1'b0, bor_pulse = 1'b0, ext_rst = 1'b0;
    logic       pwrt_en = 1'b0, osc_raw = 1'b0;
    logic [1:0] osc_mode = 2'd0;
    logic       hold_rst;
    logic [2:0] phase;
    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    pwrup_seq #(.REF_KHZ(KHZ), .OST_EDGES(EDGES)) u0 (
        .clk(clk), .por_pulse(por_pulse), .bor_pulse(bor_pulse), .ext_rst(ext_rst),
        .pwrt_en(pwrt_en), .osc_mode(osc_mode), .osc_raw(osc_raw),
        .hold_rst(hold_rst), .phase(phase)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // event pulse for one cycle; returns at the negedge showing the IDLE cycle
    task automatic fire(input int kind, input int mode, input bit en);
        @(negedge clk);
        osc_mode = 2'(mode); pwrt_en = en;
        por_pulse = (kind == 0); bor_pulse = (kind == 1); ext_rst = (kind == 2);
        @(negedge clk);
        por_pulse = 0; bor_pulse = 0; ext_rst = 0;
        chk(phase == 3'd0 && hold_rst, "R1 idle after event", int'(phase), 0);
    endtask

    task automatic measure(input int ph, input int exp_len, input string req);
        int n = 0;
        chk(phase == 3'(ph) && hold_rst, req, int'(phase), ph);
        while (phase == 3'(ph) && n < 100000) begin
            n++;
            @(negedge clk);
        end
        chk(n == exp_len, req, n, exp_len);
    endtask

    task automatic osc_pulse();
        osc_raw = 1'b1; repeat (3) @(negedge clk);
        osc_raw = 1'b0; repeat (3) @(negedge clk);
    endtask

    // drives the start-up phase to its end; returns at the negedge after exit
    task automatic run_ost();
        int n = 0;
        chk(phase == 3'd2 && hold_rst, "R5 ost entered", int'(phase), 2);
        for (int i = 0; i < EDGES - 1; i++) osc_pulse();
        repeat (6) @(negedge clk);
        chk(phase == 3'd2, "R5 ost waits for last edge", int'(phase), 2);
        osc_raw = 1'b1;
        while (phase == 3'd2 && n < 20) begin
            @(negedge clk);
            n++;
        end
        osc_raw = 1'b0;
        chk(n == 3, "R5 ost exit latency", n, 3);
    endtask

    task automatic run_seq(input int kind, input int mode, input bit en);
        bit cold = (kind != 2);
        fire(kind, mode, en);
        @(negedge clk);
        if (cold && en) measure(1, T_PW, "R3 pwrt length");
        else chk(phase != 3'd1, "R4 pwrt skipped", int'(phase), 2);
        if (mode != 0) run_ost();
        else chk(phase != 3'd2, "R6 ost skipped", int'(phase), 4);
        if (mode == 3) measure(3, T_PLL, "R7 pll length");
        else chk(phase != 3'd3, "R7 no pll", int'(phase), 4);
        chk(phase == 3'd4 && !hold_rst, "R2 sequence done", int'(phase), 4);
        repeat (5) @(negedge clk);
        chk(phase == 3'd4 && !hold_rst, "R9 done sticky", int'(phase), 4);
    endtask

    initial begin
        int n;
        // reset state
        fire(0, 0, 1'b0);
        @(negedge clk);
        chk(phase == 3'd4 && !hold_rst, "R2 rc no pwrt direct done", int'(phase), 4);

        // sweep of event kind, mode and enable
        for (int k = 0; k < 3; k++)
            for (int m = 0; m < 4; m++)
                for (int e = 0; e < 2; e++)
                    run_seq(k, m, e[0]);

        // R8: mode captured at event, later change ignored
        fire(0, 0, 1'b1);
        @(negedge clk);
        osc_mode = 2'd3; pwrt_en = 1'b0;
        measure(1, T_PW, "R8 pwrt unaffected by enable change");
        chk(phase == 3'd4, "R8 mode change ignored", int'(phase), 4);

        // R1/R4: ext restart mid power-up delay drops the delay
        fire(0, 1, 1'b1);
        repeat (50) @(negedge clk);
        chk(phase == 3'd1, "R3 in pwrt", int'(phase), 1);
        fire(2, 1, 1'b1);
        @(negedge clk);
        chk(phase == 3'd2, "R4 ext restart skips pwrt", int'(phase), 2);
        for (int i = 0; i < 4; i++) osc_pulse();
        // R1: power-on restart during start-up, counts begin anew
        fire(0, 2, 1'b1);
        @(negedge clk);
        measure(1, T_PW, "R1 restart full pwrt");
        run_ost();
        chk(phase == 3'd4, "R1 restart completes", int'(phase), 4);

        // R5: edges during power-up delay not counted
        fire(1, 1, 1'b1);
        @(negedge clk);
        n = 0;
        for (int i = 0; i < 10; i++) begin osc_pulse(); n += 6; end
        while (phase == 3'd1 && n < 100000) begin n++; @(negedge clk); end
        chk(n == T_PW, "R5 pwrt length with osc edges", n, T_PW);
        run_ost();
        chk(phase == 3'd4, "R5 full edge count needed", int'(phase), 4);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog act=1 exp=0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule